// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two predictors side by side and lets a trained per-address chooser decide which one to trust. The first predictor, the path-history side, keys a table of 2-bit counters on the outcomes of the most recent branches across the whole program. The second, the per-branch side, first looks up that branch's own recent outcomes by its address. It then uses that pattern to select a 3-bit counter. With the default parameters the state adds up to 8 Kbit of path-history counters, 8 Kbit of chooser counters, 10 Kbit of per-branch histories and 3 Kbit of per-branch counters, for 29 Kbit in total.

A lookup is combinational. The fetch stage drives the branch address and gets back the final direction, both component directions, the chooser's pick, and the two history values used for the lookup. The fetch stage keeps that snapshot with the branch. When the branch resolves, it returns the snapshot, the address and the real outcome on the update port. The block then trains all of its tables in one clock edge. The caller passes only the low `PC_W` address bits (12 by default), which are all the block uses.

Top module: `tourney_predictor`

## Requirements
- R1: The path-history table holds 2^GH_W (4096) 2-bit saturating counters (0..3), read at the current global history. `pred_global_dir` is 1 when the counter is 2 or more.
- R2: The per-branch history table holds 2^LH_AW (1024) entries of LH_W (10) bits, selected by `pc[9:0]`. The selected entry appears on `pred_lhist`, so addresses that differ only above bit 9 share an entry.
- R3: The per-branch counter table holds 2^LH_W (1024) 3-bit saturating counters (0..7), read at the per-branch history. `pred_local_dir` is 1 when the counter is 4 or more.
- R4: The chooser holds 2^PC_W (4096) 2-bit saturating counters, read at `pc[11:0]`. A counter value of 2 or 3 gives `pred_use_global`=1 and `pred_taken`=`pred_global_dir`. A value of 0 or 1 gives `pred_taken`=`pred_local_dir`.
- R5: On an update whose two snapshot directions differ, the chooser counter at `upd_pc` steps up when the path-history direction equals the outcome and down otherwise, saturating at 0 and 3. When the two directions agree, it is left unchanged.
- R6: Every update steps the path-history counter at `upd_ghist` and the per-branch counter at `upd_lhist` toward the outcome (up if taken), saturating. This happens whichever component was picked.
- R7: Every update shifts the global history left by one and puts `upd_taken` in bit 0. `pred_ghist` shows the global history.
- R8: Every update shifts the per-branch history entry at `upd_pc[9:0]` left by one, with `upd_taken` in bit 0.
- R9: After reset, every path-history counter is 1 and every per-branch counter is 3 (both weakly not taken). Every chooser counter is 1 (weakly per-branch), and both histories are zero.
- R10: When a lookup and an update occur in the same cycle, the lookup reflects the state before that update. The update is visible from the next cycle on.
- R11: While `upd_valid` is 0, no table, counter or history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Low address bits of the branch being looked up |
| pred_taken | output | 1 | Final predicted direction |
| pred_use_global | output | 1 | 1 when the chooser picks the path-history side |
| pred_global_dir | output | 1 | Path-history component direction |
| pred_local_dir | output | 1 | Per-branch component direction |
| pred_ghist | output | GH_W | Global history used for this lookup |
| pred_lhist | output | LH_W | Per-branch history used for this lookup |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | Low address bits of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_ghist | input | GH_W | Global history snapshot from the lookup |
| upd_lhist | input | LH_W | Per-branch history snapshot from the lookup |
| upd_global_dir | input | 1 | Path-history direction snapshot |
| upd_local_dir | input | 1 | Per-branch direction snapshot |

## Verification
A lookup and the training of an earlier branch can land in the same cycle. When both touch the same address or counter, the lookup must see the state from before the training (R10). The bench provokes this by running branches back to back: every cycle looks up a new branch while it retires the previous one. Some runs repeat the same address and others use addresses that alias in the per-branch table. Each lookup is judged against a model that is read before the pending update is applied to it.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Chooser decision, taken from the chooser counter msb
  typedef enum logic {
    PICK_LOCAL  = 1'b0,
    PICK_GLOBAL = 1'b1
  } pick_e;

  // Reset levels of each counter family
  localparam int unsigned GCTR_INIT = 1;  // weakly not taken, 2-bit
  localparam int unsigned LCTR_INIT = 3;  // weakly not taken, 3-bit
  localparam int unsigned SCTR_INIT = 1;  // weakly per-branch, 2-bit
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int          AW   = 12,
  parameter int          CW   = 2,
  parameter int unsigned INIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_dir,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic          wr_up
);
  localparam int            DEPTH = 1 << AW;
  localparam logic [CW-1:0] MAXV  = '1;
  localparam logic [CW-1:0] INITV = CW'(INIT);

  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] cur_q;
  logic [CW-1:0] nxt_d;

  assign rd_dir = mem[rd_idx][CW-1];

  // next value of the entry being trained
  always_comb begin
    cur_q = mem[wr_idx];
    nxt_d = cur_q;
    if (wr_up) begin
      if (cur_q != MAXV) nxt_d = cur_q + 1'b1;
    end else begin
      if (cur_q != '0) nxt_d = cur_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INITV;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt_d;
    end
  end

  assert_ctr_top_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && mem[wr_idx] == MAXV) |=> (mem[$past(wr_idx)] == MAXV));

  assert_ctr_bottom_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && mem[wr_idx] == '0) |=> (mem[$past(wr_idx)] == '0));

  assert_ctr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (mem[$past(wr_idx)] == $past(mem[wr_idx])));
endmodule

// File: rtl/tp_lhist_table.sv
module tp_lhist_table #(
  parameter int AW = 10,
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [HW-1:0] rd_hist,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic          wr_bit
);
  localparam int DEPTH = 1 << AW;

  logic [HW-1:0] mem [DEPTH];
  logic [HW-1:0] nxt_d;

  assign rd_hist = mem[rd_idx];

  always_comb begin
    nxt_d = {mem[wr_idx][HW-2:0], wr_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt_d;
    end
  end

  assert_lhist_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_idx)][0] == $past(wr_bit)) &&
              (mem[$past(wr_idx)][HW-1:1] == $past(mem[wr_idx][HW-2:0])));
endmodule

// File: rtl/tp_ghist_reg.sv
module tp_ghist_reg #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          shift_bit,
  output logic [HW-1:0] hist
);
  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {hist_q[HW-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;

  assert_ghist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist[0] == $past(shift_bit)) && (hist[HW-1:1] == $past(hist[HW-2:0])));

  assert_ghist_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int PC_W  = 12,
  parameter int GH_W  = 12,
  parameter int LH_AW = 10,
  parameter int LH_W  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_use_global,
  output logic            pred_global_dir,
  output logic            pred_local_dir,
  output logic [GH_W-1:0] pred_ghist,
  output logic [LH_W-1:0] pred_lhist,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [GH_W-1:0] upd_ghist,
  input  logic [LH_W-1:0] upd_lhist,
  input  logic            upd_global_dir,
  input  logic            upd_local_dir
);
  import tp_pkg::*;

  localparam int GCTR_W = 2;
  localparam int LCTR_W = 3;
  localparam int SCTR_W = 2;

  logic [GH_W-1:0] ghist;
  logic [LH_W-1:0] lhist;
  logic            g_dir;
  logic            l_dir;
  logic            sel_msb;
  pick_e           pick;
  logic            sel_wr_en;
  logic            sel_wr_up;

  // global history register
  tp_ghist_reg #(.HW(GH_W)) u_ghr (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .shift_bit(upd_taken),
    .hist(ghist)
  );

  // path-history counters
  tp_ctr_table #(.AW(GH_W), .CW(GCTR_W), .INIT(GCTR_INIT)) u_gctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_dir(g_dir),
    .wr_en(upd_valid), .wr_idx(upd_ghist), .wr_up(upd_taken)
  );

  // per-branch histories
  tp_lhist_table #(.AW(LH_AW), .HW(LH_W)) u_lht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_pc[LH_AW-1:0]), .rd_hist(lhist),
    .wr_en(upd_valid), .wr_idx(upd_pc[LH_AW-1:0]), .wr_bit(upd_taken)
  );

  // per-branch counters
  tp_ctr_table #(.AW(LH_W), .CW(LCTR_W), .INIT(LCTR_INIT)) u_lctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lhist), .rd_dir(l_dir),
    .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
  );

  // chooser trains only when the components disagreed
  always_comb begin
    sel_wr_en = upd_valid && (upd_global_dir != upd_local_dir);
    sel_wr_up = (upd_global_dir == upd_taken);
  end

  tp_ctr_table #(.AW(PC_W), .CW(SCTR_W), .INIT(SCTR_INIT)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_pc), .rd_dir(sel_msb),
    .wr_en(sel_wr_en), .wr_idx(upd_pc), .wr_up(sel_wr_up)
  );

  always_comb begin
    pick       = pick_e'(sel_msb);
    pred_taken = (pick == PICK_GLOBAL) ? g_dir : l_dir;
  end

  assign pred_use_global = sel_msb;
  assign pred_global_dir = g_dir;
  assign pred_local_dir  = l_dir;
  assign pred_ghist      = ghist;
  assign pred_lhist      = lhist;

  assert_pick_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_global_dir == pred_local_dir) |-> (pred_taken == pred_global_dir));

  assert_sel_hold_on_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_global_dir == upd_local_dir) |=>
      (u_sel.mem[$past(upd_pc)] == $past(u_sel.mem[upd_pc])));
endmodule

// File: tb/tb_tourney_predictor.sv
module tb_tourney_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pred_pc = '0;
  logic        pred_taken, pred_use_global, pred_global_dir, pred_local_dir;
  logic [11:0] pred_ghist;
  logic [9:0]  pred_lhist;
  logic        upd_valid = 1'b0;
  logic [11:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [11:0] upd_ghist = '0;
  logic [9:0]  upd_lhist = '0;
  logic        upd_global_dir = 1'b0;
  logic        upd_local_dir = 1'b0;

  always #5 clk = ~clk;

  tourney_predictor dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_use_global(pred_use_global),
    .pred_global_dir(pred_global_dir), .pred_local_dir(pred_local_dir),
    .pred_ghist(pred_ghist), .pred_lhist(pred_lhist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_ghist(upd_ghist), .upd_lhist(upd_lhist),
    .upd_global_dir(upd_global_dir), .upd_local_dir(upd_local_dir)
  );

  typedef struct packed {
    logic [3:0]  ctx;
    logic        tk;
    logic        ug;
    logic        gd;
    logic        ld;
    logic [11:0] gh;
    logic [9:0]  lh;
    logic [11:0] pc;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   bad = 0;
  bit   done = 1'b0;

  // reference state
  logic [1:0]  gctr_m [4096];
  logic [2:0]  lctr_m [1024];
  logic [1:0]  sel_m  [4096];
  logic [9:0]  lht_m  [1024];
  logic [11:0] ghr_m;
  exp_t        pend;
  bit          pend_v = 1'b0;

  function automatic string ctx_name(input logic [3:0] c);
    case (c)
      4'd0: return "R9 reset";
      4'd1: return "R6 training";
      4'd2: return "R5 chooser";
      4'd3: return "R2/R8 alias";
      4'd4: return "R11 idle";
      default: return "R10 overlap";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req,
                     input logic [3:0] c, input logic [11:0] pc);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] pc=%h act=%0h exp=%0h", req, ctx_name(c), pc, act, exp);
    end
  endtask

  // monitor: compare each lookup against its expected item
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(32'(pred_global_dir), 32'(e.gd), "R1", e.ctx, e.pc);
      chk(32'(pred_lhist),      32'(e.lh), "R2", e.ctx, e.pc);
      chk(32'(pred_local_dir),  32'(e.ld), "R3", e.ctx, e.pc);
      chk(32'(pred_use_global), 32'(e.ug), "R4", e.ctx, e.pc);
      chk(32'(pred_taken),      32'(e.tk), "R4", e.ctx, e.pc);
      chk(32'(pred_ghist),      32'(e.gh), "R7", e.ctx, e.pc);
    end
  end

  function automatic logic [1:0] sat2(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  function automatic logic [2:0] sat3(input logic [2:0] v, input logic up);
    if (up) return (v == 3'd7) ? v : v + 3'd1;
    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  // one cycle: look up pc, and retire the pending branch in the same cycle
  task automatic step(input logic [11:0] pc, input logic taken, input bit commit,
                      input logic [3:0] c);
    exp_t e;
    @(posedge clk);
    #1;
    pred_pc = pc;
    e.ctx = c;
    e.pc  = pc;
    e.gh  = ghr_m;
    e.lh  = lht_m[pc[9:0]];
    e.gd  = gctr_m[e.gh][1];
    e.ld  = lctr_m[e.lh][2];
    e.ug  = sel_m[pc][1];
    e.tk  = e.ug ? e.gd : e.ld;
    q.push_back(e);
    if (pend_v) begin
      upd_valid      = 1'b1;
      upd_pc         = pend.pc;
      upd_taken      = pend.tk;
      upd_ghist      = pend.gh;
      upd_lhist      = pend.lh;
      upd_global_dir = pend.gd;
      upd_local_dir  = pend.ld;
      gctr_m[pend.gh] = sat2(gctr_m[pend.gh], pend.tk);
      lctr_m[pend.lh] = sat3(lctr_m[pend.lh], pend.tk);
      if (pend.gd != pend.ld) sel_m[pend.pc] = sat2(sel_m[pend.pc], pend.gd == pend.tk);
      ghr_m = {ghr_m[10:0], pend.tk};
      lht_m[pend.pc[9:0]] = {lht_m[pend.pc[9:0]][8:0], pend.tk};
      pend_v = 1'b0;
    end else begin
      upd_valid = 1'b0;
    end
    if (commit) begin
      pend    = e;
      pend.tk = taken;
      pend_v  = 1'b1;
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 4096; i++) begin gctr_m[i] = 2'd1; sel_m[i] = 2'd1; end
    for (int i = 0; i < 1024; i++) begin lctr_m[i] = 3'd3; lht_m[i] = '0; end
    ghr_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state seen through lookups, no training
    step(12'h000, 1'b0, 1'b0, 4'd0);
    step(12'hFFF, 1'b0, 1'b0, 4'd0);

    // R6/R1/R3: one branch always taken, counters climb and saturate
    for (int i = 0; i < 20; i++) step(12'h040, 1'b1, 1'b1, 4'd1);
    // then always not taken, climb back down
    for (int i = 0; i < 20; i++) step(12'h040, 1'b0, 1'b1, 4'd1);

    // R5: loop-style branch, 9 taken then 1 exit, components disagree often
    for (int r = 0; r < 12; r++)
      for (int i = 0; i < 10; i++) step(12'h123, (i != 9), 1'b1, 4'd2);

    // R2/R8: addresses that alias in the per-branch table only
    for (int i = 0; i < 16; i++) begin
      step(12'h523, 1'b1, 1'b1, 4'd3);
      step(12'h923, 1'b0, 1'b1, 4'd3);
      step(12'h123, i[0], 1'b1, 4'd3);
    end

    // R11: retire the last branch, then idle lookups must not move state
    step(12'h523, 1'b0, 1'b0, 4'd4);
    for (int i = 0; i < 6; i++) step(12'h523, 1'b0, 1'b0, 4'd4);
    for (int i = 0; i < 4; i++) step(12'h040, 1'b0, 1'b0, 4'd4);

    // R10: back-to-back mixed traffic, correlated and random outcomes
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      logic [11:0] pc;
      logic        tk;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pc = {lfsr[2], 7'h00, lfsr[1:0], 2'b00};
      case (lfsr[1:0])
        2'd0: tk = ghr_m[0] ^ ghr_m[1];
        2'd1: tk = 1'b1;
        2'd2: tk = lfsr[7];
        default: tk = ~lht_m[pc[9:0]][1];
      endcase
      step(pc, tk, 1'b1, 4'd5);
    end
    step(12'h000, 1'b0, 1'b0, 4'd5);
    @(posedge clk);
    #1 upd_valid = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL R10 watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule